// File: doc/BRIEF.md
# Timed Unsigned Divider

This block divides a 32-bit unsigned dividend by a 16-bit unsigned divisor. It returns a 16-bit quotient and a 16-bit remainder. It also returns a microcycle count that models the data-dependent cost of a shift-and-subtract microprogram. The surrounding execution model uses that count to charge realistic timing for the operation.

Two cases finish one clock after the start strobe, before any loop runs: a zero divisor and a quotient too wide for 16 bits. In both cases the quotient and remainder outputs keep their previous values. For a normal divide, the block runs one iteration per clock. It restores the quotient bit by bit and adds a per-iteration charge of 2, 3 or 4 microcycles to a running count. A single-cycle done strobe marks completion, and every result output holds until the next completion.

Top module: `udiv_timed`

## Requirements
- R1: While reset is asserted and after its release, `done_o`, `dz_o`, `ov_o`, `quotient_o`, `remainder_o` and `cycles_o` are all zero.
- R2: If a start is accepted with a divisor of zero, `done_o` is high in the cycle after the sampling edge. In that completion `dz_o`=1, `ov_o`=0 and `cycles_o`=4, and `quotient_o` and `remainder_o` keep their previous values.
- R3: If a start is accepted with a nonzero divisor and dividend bits [31:16] greater than or equal to the divisor, `done_o` is high in the cycle after the sampling edge. In that completion `ov_o`=1, `dz_o`=0 and `cycles_o`=3, and `quotient_o` and `remainder_o` keep their previous values.
- R4: On a normal completion, `quotient_o` equals dividend / divisor and `remainder_o` equals dividend % divisor, both unsigned.
- R5: On a normal completion, `cycles_o` is built as follows:
  - It starts at 3.
  - The divisor is aligned as divisor<<16, and a 32-bit working value starts at the dividend.
  - Each of the first 15 iterations then adds a charge. If bit 31 of the working value is 1, it adds 2, and the working value becomes (w<<1) minus the aligned divisor. If bit 31 is 0 and (w<<1) is greater than or equal to the aligned divisor, it adds 3 and subtracts. Otherwise it adds 4 and only shifts.
  - A 16th, uncharged step yields the last quotient bit.
- R6: On a normal divide, `done_o` rises after the 16th rising edge that follows the edge sampling `start_i`. It stays high for exactly one cycle when no new start follows.
- R7: Between completions, `quotient_o`, `remainder_o`, `cycles_o`, `dz_o` and `ov_o` do not change.
- R8: A `start_i` pulse during a running divide is ignored. The running divide completes on time with its own operands' results.
- R9: A normal completion clears `dz_o` and `ov_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| dividend_i | input | 32 | Unsigned dividend |
| divisor_i | input | 16 | Unsigned divisor |
| quotient_o | output | 16 | Quotient of the last normal completion |
| remainder_o | output | 16 | Remainder of the last normal completion |
| dz_o | output | 1 | Last completion hit a zero divisor |
| ov_o | output | 1 | Last completion overflowed |
| done_o | output | 1 | One-cycle completion strobe |
| cycles_o | output | 6 | Microcycle cost of the last completion |

## Verification
A wrong internal state shows up at the ports in three ways:
- A corrupted working value or a misrouted subtraction gives a wrong quotient or remainder at the next done strobe. It also usually shifts `cycles_o`, because each iteration's charge depends on the same comparison.
- A bad iteration counter moves the done strobe away from the 16-cycle mark, which the bench sees as a latency mismatch in that same operation.
- A controller that leaves the running state when a start arrives mid-run shows as an early done, or as results taken from the intruding operands.

Operand patterns are chosen to drive every iteration path: a working value with its top bit set, tight remainders, and maximum quotients.

// File: rtl/udiv_timed_pkg.sv
package udiv_timed_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  typedef logic [2:0] cost_t;
  localparam cost_t COST_ZERO  = 3'd4;
  localparam cost_t COST_OVF   = 3'd3;
  localparam cost_t COST_ENTRY = 3'd3;
  localparam cost_t COST_MSB   = 3'd2;
  localparam cost_t COST_SUB   = 3'd3;
  localparam cost_t COST_KEEP  = 3'd4;
endpackage

// File: rtl/udiv_precheck.sv
module udiv_precheck #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0]   divisor_i,
  output logic                zero_o,
  output logic                ovf_o
);
  always_comb begin
    zero_o = (divisor_i == '0);
    // quotient cannot fit when the upper half already reaches the divisor
    ovf_o  = !zero_o && (dividend_i[2*DATA_W-1:DATA_W] >= divisor_i);
  end
endmodule

// File: rtl/udiv_step.sv
module udiv_step
  import udiv_timed_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [2*DATA_W-1:0] w_i,
  input  logic [2*DATA_W-1:0] d_al_i,
  output logic [2*DATA_W-1:0] w_o,
  output logic                q_bit_o,
  output cost_t               cost_o
);
  logic [2*DATA_W-1:0] w_sh;

  always_comb begin
    w_sh = {w_i[2*DATA_W-2:0], 1'b0};
    if (w_i[2*DATA_W-1]) begin
      // shifted value exceeds the aligned divisor, wrap-around subtract is exact
      w_o     = w_sh - d_al_i;
      q_bit_o = 1'b1;
      cost_o  = COST_MSB;
    end else if (w_sh >= d_al_i) begin
      w_o     = w_sh - d_al_i;
      q_bit_o = 1'b1;
      cost_o  = COST_SUB;
    end else begin
      w_o     = w_sh;
      q_bit_o = 1'b0;
      cost_o  = COST_KEEP;
    end
  end
endmodule

// File: rtl/udiv_timed.sv
module udiv_timed
  import udiv_timed_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = $clog2(4 * DATA_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2*DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0]   divisor_i,
  output logic [DATA_W-1:0]   quotient_o,
  output logic [DATA_W-1:0]   remainder_o,
  output logic                dz_o,
  output logic                ov_o,
  output logic                done_o,
  output logic [CNT_W-1:0]    cycles_o
);
  localparam int unsigned IDX_W = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  st_e                 state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [2*DATA_W-1:0] w_q;
  logic [DATA_W-1:0]   d_q;
  logic [DATA_W-2:0]   q_q;
  logic [CNT_W-1:0]    acc_q;

  logic                zero_det, ovf_det;
  logic [2*DATA_W-1:0] w_nxt;
  logic                q_bit;
  cost_t               step_cost;
  logic                busy, last_step;

  assign busy      = (state_q == ST_RUN);
  assign last_step = (idx_q == LAST_IDX);

  udiv_precheck #(.DATA_W(DATA_W)) u_precheck (
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .zero_o     (zero_det),
    .ovf_o      (ovf_det)
  );

  udiv_step #(.DATA_W(DATA_W)) u_step (
    .w_i     (w_q),
    .d_al_i  ({d_q, {DATA_W{1'b0}}}),
    .w_o     (w_nxt),
    .q_bit_o (q_bit),
    .cost_o  (step_cost)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      w_q         <= '0;
      d_q         <= '0;
      q_q         <= '0;
      acc_q       <= '0;
      quotient_o  <= '0;
      remainder_o <= '0;
      dz_o        <= 1'b0;
      ov_o        <= 1'b0;
      done_o      <= 1'b0;
      cycles_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (zero_det) begin
              done_o   <= 1'b1;
              dz_o     <= 1'b1;
              ov_o     <= 1'b0;
              cycles_o <= CNT_W'(COST_ZERO);
            end else if (ovf_det) begin
              done_o   <= 1'b1;
              dz_o     <= 1'b0;
              ov_o     <= 1'b1;
              cycles_o <= CNT_W'(COST_OVF);
            end else begin
              state_q <= ST_RUN;
              idx_q   <= '0;
              w_q     <= dividend_i;
              d_q     <= divisor_i;
              q_q     <= '0;
              acc_q   <= CNT_W'(COST_ENTRY);
            end
          end
        end
        ST_RUN: begin
          w_q   <= w_nxt;
          q_q   <= {q_q[DATA_W-3:0], q_bit};
          idx_q <= idx_q + 1'b1;
          if (!last_step) begin
            acc_q <= acc_q + CNT_W'(step_cost);
          end else begin
            // final step resolves bit 0 without a charge
            state_q     <= ST_IDLE;
            done_o      <= 1'b1;
            dz_o        <= 1'b0;
            ov_o        <= 1'b0;
            quotient_o  <= {q_q, q_bit};
            remainder_o <= w_nxt[2*DATA_W-1:DATA_W];
            cycles_o    <= acc_q;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/udiv_timed_chk.sv
module udiv_timed_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy,
  input logic              last_step,
  input logic              done_o,
  input logic              dz_o,
  input logic              ov_o,
  input logic [DATA_W-1:0] quotient_o,
  input logic [DATA_W-1:0] remainder_o,
  input logic [CNT_W-1:0]  cycles_o
);
  localparam int unsigned MIN_CYC = 3 + 2 * (DATA_W - 1);
  localparam int unsigned MAX_CYC = 3 + 4 * (DATA_W - 1);

  // R2
  dz_cost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && dz_o |-> (cycles_o == CNT_W'(4)) && !ov_o);

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ov_o |-> (cycles_o == CNT_W'(3)) && !dz_o);

  // R5
  cost_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !dz_o && !ov_o |->
      (cycles_o >= CNT_W'(MIN_CYC)) && (cycles_o <= CNT_W'(MAX_CYC)));

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(quotient_o) && $stable(remainder_o) && $stable(cycles_o)
                && $stable(dz_o) && $stable(ov_o));

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !last_step |=> busy && !done_o);
endmodule

bind udiv_timed udiv_timed_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy        (busy),
  .last_step   (last_step),
  .done_o      (done_o),
  .dz_o        (dz_o),
  .ov_o        (ov_o),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .cycles_o    (cycles_o)
);

// File: tb/udiv_timed_bench.sv
module udiv_timed_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [15:0] divisor_i = '0;
  logic [15:0] quotient_o, remainder_o;
  logic        dz_o, ov_o, done_o;
  logic [5:0]  cycles_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  udiv_timed u_udiv_timed (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quotient_o(quotient_o), .remainder_o(remainder_o),
    .dz_o(dz_o), .ov_o(ov_o), .done_o(done_o), .cycles_o(cycles_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_cost(input logic [31:0] n, input logic [15:0] d);
    logic [31:0] w;
    logic [31:0] dal;
    int c;
    w = n; dal = {d, 16'h0}; c = 3;
    for (int i = 0; i < 15; i++) begin
      if (w[31]) begin
        w = (w << 1) - dal; c += 2;
      end else begin
        w = w << 1;
        if (w >= dal) begin w = w - dal; c += 3; end
        else c += 4;
      end
    end
    return c;
  endfunction

  // issues one start and returns edges until done is seen
  task automatic run_div(input logic [31:0] n, input logic [15:0] d, output int lat);
    @(negedge clk_i);
    dividend_i = n; divisor_i = d; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 40) begin
      @(negedge clk_i);
      lat++;
    end
  endtask

  task automatic t_reset();
    check(done_o == 0 && dz_o == 0 && ov_o == 0, "R1 flags in reset", {done_o, dz_o, ov_o}, 0);
    check(quotient_o == 0 && remainder_o == 0 && cycles_o == 0, "R1 data in reset",
          quotient_o + remainder_o + cycles_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check(done_o == 0 && cycles_o == 0, "R1 after release", done_o + cycles_o, 0);
  endtask

  task automatic t_normal(input logic [31:0] n, input logic [15:0] d);
    int lat;
    run_div(n, d, lat);
    check(lat == 17, "R6 latency", lat, 17);
    check(quotient_o == 16'(n / d), "R4 quotient", quotient_o, n / d);
    check(remainder_o == 16'(n % d), "R4 remainder", remainder_o, n % d);
    check(int'(cycles_o) == model_cost(n, d), "R5 cycles", cycles_o, model_cost(n, d));
    check(dz_o == 0 && ov_o == 0, "R9 flags clear", {dz_o, ov_o}, 0);
    @(negedge clk_i);
    check(done_o == 0, "R6 one-cycle done", done_o, 0);
  endtask

  task automatic t_zero();
    int lat;
    logic [15:0] pq, pr;
    pq = quotient_o; pr = remainder_o;
    run_div(32'h1234_5678, 16'h0, lat);
    check(lat == 1, "R2 latency", lat, 1);
    check(dz_o == 1 && ov_o == 0, "R2 flags", {dz_o, ov_o}, 2);
    check(cycles_o == 4, "R2 cycles", cycles_o, 4);
    check(quotient_o == pq && remainder_o == pr, "R2 results held", quotient_o, pq);
  endtask

  task automatic t_overflow(input logic [31:0] n, input logic [15:0] d);
    int lat;
    logic [15:0] pq, pr;
    pq = quotient_o; pr = remainder_o;
    run_div(n, d, lat);
    check(lat == 1, "R3 latency", lat, 1);
    check(ov_o == 1 && dz_o == 0, "R3 flags", {dz_o, ov_o}, 1);
    check(cycles_o == 3, "R3 cycles", cycles_o, 3);
    check(quotient_o == pq && remainder_o == pr, "R3 results held", quotient_o, pq);
  endtask

  task automatic t_hold();
    logic [15:0] pq;
    logic [5:0] pc;
    pq = quotient_o; pc = cycles_o;
    repeat (5) @(negedge clk_i);
    check(quotient_o == pq && cycles_o == pc && done_o == 0, "R7 hold", quotient_o, pq);
  endtask

  task automatic t_busy_start();
    int lat;
    logic [31:0] n = 32'h0003_0F21;
    logic [15:0] d = 16'h0011;
    @(negedge clk_i);
    dividend_i = n; divisor_i = d; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk_i); lat++; end
    dividend_i = 32'h0000_0009; divisor_i = 16'h0000; start_i = 1'b1;
    @(negedge clk_i); lat++;
    start_i = 1'b0;
    check(done_o == 0, "R8 no early done", done_o, 0);
    while (!done_o && lat < 40) begin @(negedge clk_i); lat++; end
    check(lat == 17, "R8 latency kept", lat, 17);
    check(quotient_o == 16'(n / d) && dz_o == 0, "R8 own result", quotient_o, n / d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R6 actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_normal(32'd100, 16'd7);
    t_zero();
    t_normal(32'hFFFE_FFFF, 16'hFFFF);
    t_overflow(32'h0007_0000, 16'h0007);
    t_normal(32'h0000_0000, 16'h0001);
    t_overflow(32'hFFFF_FFFF, 16'h0001);
    t_normal(32'h0000_FFFF, 16'h0001);
    t_hold();
    t_normal(32'h7FFF_8000, 16'h8000);
    t_normal(32'h1234_5678, 16'h9ABC);
    t_busy_start();
    t_normal(32'h0000_0005, 16'hFFFF);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule